// File: doc/BRIEF.md
# Bitfield extract unit

This unit takes a 32-bit source word, isolates a contiguous run of bits chosen at run time by a starting bit position and a bit count, and returns that run right-aligned in a 32-bit result. A mode input selects how the bits above the field are filled. In unsigned mode they are cleared. In signed mode each of them copies the field's top bit.

A request is presented for one clock with `reqValid` high. The unit checks the operands in the same cycle. A legal request loads the result register and pulses `resValid` on the following clock. An illegal request pulses `illegal` on the following clock instead, and the result register keeps its previous value.

A request is illegal when the position or count is out of range, or when either register index names the stack pointer (13) or the program counter (15). The unit has no condition-flag outputs.

Top module: `bfx_unit`

## Requirements
- R1: With `isSigned` low, result bits [fieldLen-1:0] equal source bits [fieldLsb+fieldLen-1:fieldLsb], and every higher result bit is 0. For example, position 9 with count 10 returns source bits 18..9.
- R2: With `isSigned` high, the low bits are the same as in R1, and every higher result bit equals source bit fieldLsb+fieldLen-1. For example, position 20 with count 4 returns source bits 23..20, widened by their top bit.
- R3: A request with `fieldLsb` greater than 31 is illegal.
- R4: A request with `fieldLen` equal to 0, or with `fieldLsb + fieldLen` greater than 32, is illegal.
- R5: A request is illegal when `dstIdx` or `srcIdx` equals 13 or 15. Any other index, for example 14, is accepted.
- R6: An illegal request pulses `illegal` and does not raise `resValid`. `result` keeps the value of the last legal request, or 0 if there has been none since reset.
- R7: `resValid` or `illegal` is high for exactly one cycle, one clock after each request. Neither rises without a request. Requests may arrive on consecutive cycles.
- R8: Synchronous reset clears `result`, `resValid` and `illegal` to 0.
- R9: Position 0 with count 32 returns the source word unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, one cycle per request |
| srcWord | input | 32 | Source word |
| fieldLsb | input | 6 | Lowest bit position of the field |
| fieldLen | input | 6 | Field width in bits |
| isSigned | input | 1 | 1 selects sign fill, 0 selects zero fill |
| dstIdx | input | 4 | Destination register index (legality check only) |
| srcIdx | input | 4 | Source register index (legality check only) |
| result | output | 32 | Registered extracted word |
| resValid | output | 1 | One-cycle pulse for a legal request's result |
| illegal | output | 1 | One-cycle pulse for a rejected request |

## Verification
Every outcome, legal or rejected, is due on the first rising edge after the request's cycle. The bench therefore records, with each expected item, the cycle number of that edge. The monitor samples on the falling edge after it. There it compares the strobes, the result word and the arrival cycle against the oldest queued item. A strobe that arrives with nothing queued counts as a mismatch, and so does an item still queued after its due cycle. Back-to-back requests confirm that one result is due per cycle, in request order.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef struct packed {
    logic load;     // legal request: capture the extracted word
    logic flagBad;  // rejected request: pulse the illegal flag
  } bfxStrobe_t;
endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1,
  parameter int REG_W  = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15
) (
  input  logic             reqValid,
  input  logic [LEN_W-1:0] fieldLsb,
  input  logic [LEN_W-1:0] fieldLen,
  input  logic [REG_W-1:0] dstIdx,
  input  logic [REG_W-1:0] srcIdx,
  output bfxStrobe_t       strobes
);
  localparam logic [REG_W-1:0] spCode = REG_W'(SP_IDX);
  localparam logic [REG_W-1:0] pcCode = REG_W'(PC_IDX);

  logic             lsbOk, lenOk, regOk, legal;
  logic [LEN_W:0]   fieldEnd;

  always_comb begin
    fieldEnd = {1'b0, fieldLsb} + {1'b0, fieldLen};
    lsbOk    = fieldLsb < LEN_W'(DATA_W);
    lenOk    = (fieldLen != '0) && (fieldEnd <= (LEN_W+1)'(DATA_W));
    regOk    = (dstIdx != spCode) && (dstIdx != pcCode) &&
               (srcIdx != spCode) && (srcIdx != pcCode);
    legal    = lsbOk && lenOk && regOk;
    strobes.load    = reqValid && legal;
    strobes.flagBad = reqValid && !legal;
  end
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  bfxStrobe_t        strobes,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [LEN_W-1:0]  fieldLsb,
  input  logic [LEN_W-1:0]  fieldLen,
  input  logic              isSigned,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              illegal
);
  localparam int POS_W = LEN_W - 1;

  logic [DATA_W-1:0] aligned, mask, extended;
  logic [POS_W-1:0]  topIdx;
  logic              signFill;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = LEN_W'(i) < fieldLen;
    end
  endgenerate

  always_comb begin
    aligned  = srcWord >> fieldLsb;
    topIdx   = POS_W'(fieldLen - 1'b1);
    signFill = isSigned && aligned[topIdx];
    extended = (aligned & mask) | ({DATA_W{signFill}} & ~mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      resValid <= strobes.load;
      illegal  <= strobes.flagBad;
      if (strobes.load) result <= extended;
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1,
  parameter int REG_W  = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [LEN_W-1:0]  fieldLsb,
  input  logic [LEN_W-1:0]  fieldLen,
  input  logic              isSigned,
  input  logic [REG_W-1:0]  dstIdx,
  input  logic [REG_W-1:0]  srcIdx,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic              illegal
);
  bfxStrobe_t strobes;

  bfx_ctrl #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .REG_W(REG_W),
    .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)
  ) ctrl (
    .reqValid(reqValid), .fieldLsb(fieldLsb), .fieldLen(fieldLen),
    .dstIdx(dstIdx), .srcIdx(srcIdx), .strobes(strobes)
  );

  bfx_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .srcWord(srcWord),
    .fieldLsb(fieldLsb), .fieldLen(fieldLen), .isSigned(isSigned),
    .result(result), .resValid(resValid), .illegal(illegal)
  );
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1,
  parameter int REG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [DATA_W-1:0] srcWord,
  input logic [LEN_W-1:0]  fieldLsb,
  input logic [LEN_W-1:0]  fieldLen,
  input logic [REG_W-1:0]  dstIdx,
  input logic [REG_W-1:0]  srcIdx,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic              illegal
);
  // R7
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid || illegal) |-> $past(reqValid));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(resValid && illegal));

  // R6
  hold_on_reject_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(result));

  // R5
  reserved_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (dstIdx == REG_W'(13) || dstIdx == REG_W'(15) ||
                  srcIdx == REG_W'(13) || srcIdx == REG_W'(15)))
    |=> (illegal && !resValid));

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && fieldLen == '0) |=> (illegal && !resValid));

  // R3
  lsb_range_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && fieldLsb >= LEN_W'(DATA_W)) |=> illegal);

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && fieldLsb == '0 && fieldLen == LEN_W'(DATA_W) &&
     dstIdx == REG_W'(0) && srcIdx == REG_W'(1))
    |=> (resValid && result == $past(srcWord)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!resValid && !illegal && result == '0));
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W), .REG_W(REG_W)) chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .srcWord(srcWord),
  .fieldLsb(fieldLsb), .fieldLen(fieldLen), .dstIdx(dstIdx), .srcIdx(srcIdx),
  .result(result), .resValid(resValid), .illegal(illegal)
);

// File: tb/bfx_unit_test.sv
module bfx_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] srcWord = '0;
  logic [5:0]  fieldLsb = '0;
  logic [5:0]  fieldLen = 6'd1;
  logic        isSigned = 1'b0;
  logic [3:0]  dstIdx = 4'd0;
  logic [3:0]  srcIdx = 4'd1;
  logic [31:0] result;
  logic        resValid;
  logic        illegal;

  bfx_unit uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .srcWord(srcWord),
    .fieldLsb(fieldLsb), .fieldLen(fieldLen), .isSigned(isSigned),
    .dstIdx(dstIdx), .srcIdx(srcIdx), .result(result),
    .resValid(resValid), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        bad;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t    sb[$];
  int          cycle = 0;
  int          compared = 0;
  int          mismatched = 0;
  logic [31:0] lastGood = '0;
  bit          done = 0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic logic [31:0] model(logic [31:0] s, int lsb, int len, logic sg);
    logic [31:0] r;
    logic top;
    top = s[lsb+len-1];
    for (int k = 0; k < 32; k++)
      r[k] = (k < len) ? s[lsb+k] : (sg & top);
    return r;
  endfunction

  function automatic bit isLegal(int lsb, int len, int d, int s);
    if (lsb > 31) return 0;
    if (len == 0 || lsb + len > 32) return 0;
    if (d == 13 || d == 15 || s == 13 || s == 15) return 0;
    return 1;
  endfunction

  task automatic send(logic [31:0] w, int lsb, int len, logic sg, int d, int s, string tag);
    expItem_t e;
    @(negedge clk);
    reqValid = 1'b1; srcWord = w; fieldLsb = 6'(lsb); fieldLen = 6'(len);
    isSigned = sg; dstIdx = 4'(d); srcIdx = 4'(s);
    e.bad = !isLegal(lsb, len, d, s);
    if (!e.bad) lastGood = model(w, lsb, len, sg);
    e.res = lastGood;
    e.due = cycle + 1;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  task automatic checkReset(string tag);
    compared++;
    if (result !== 32'h0 || resValid !== 1'b0 || illegal !== 1'b0) begin
      mismatched++;
      $display("FAIL %s: result=%h valid=%b illegal=%b expected 0/0/0", tag, result, resValid, illegal);
    end
  endtask

  // Monitor: pops one expected item per outcome strobe
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (resValid || illegal) begin
        if (sb.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R7: valid=%b illegal=%b with no request, expected 0/0", resValid, illegal);
        end else begin
          expItem_t e;
          e = sb.pop_front();
          compared++;
          if (resValid !== !e.bad || illegal !== e.bad || result !== e.res || cycle != e.due) begin
            mismatched++;
            $display("FAIL %s: valid=%b illegal=%b result=%h cycle=%0d, expected valid=%b illegal=%b result=%h cycle=%0d",
                     e.tag, resValid, illegal, result, cycle, !e.bad, e.bad, e.res, e.due);
          end
        end
      end else if (sb.size() > 0 && sb[0].due < cycle) begin
        expItem_t e;
        e = sb.pop_front();
        compared++; mismatched++;
        $display("FAIL R7 (%s): no strobe at cycle %0d, expected one at cycle %0d", e.tag, cycle, e.due);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: run still active, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset("R8 initial reset");
    rst = 1'b0;
    idle(2);
    checkReset("R6 no result before first legal request");

    send(32'hABCD_1234, 9, 10, 1'b0, 8, 11, "R1 count 10 at 9 unsigned");
    idle(1);
    send(32'h00F0_0000, 20, 4, 1'b1, 0, 1, "R2 count 4 at 20 signed, top set");
    send(32'h0070_0000, 20, 4, 1'b1, 0, 1, "R2 count 4 at 20 signed, top clear");
    send(32'h00F0_0000, 20, 4, 1'b0, 0, 1, "R1 count 4 at 20 unsigned");
    send(32'h8000_0000, 31, 1, 1'b1, 2, 3, "R2 single top bit signed");
    send(32'h8000_0000, 31, 1, 1'b0, 2, 3, "R1 single top bit unsigned");
    send(32'hDEAD_BEEF, 0, 32, 1'b0, 0, 1, "R9 passthrough unsigned");
    send(32'h8BAD_F00D, 0, 32, 1'b1, 0, 1, "R9 passthrough signed");
    send(32'h1234_5678, 32, 1, 1'b0, 0, 1, "R3 position 32");
    send(32'h1234_5678, 40, 4, 1'b1, 0, 1, "R3 position 40");
    send(32'h1234_5678, 4, 0, 1'b0, 0, 1, "R4 zero count");
    send(32'h1234_5678, 10, 23, 1'b0, 0, 1, "R4 field past bit 31");
    send(32'h1234_5678, 0, 33, 1'b1, 0, 1, "R4 count 33");
    send(32'hFFFF_FFFF, 1, 31, 1'b0, 0, 1, "R4 boundary legal 1+31");
    send(32'h1234_5678, 0, 8, 1'b0, 13, 1, "R5 destination 13");
    send(32'h1234_5678, 0, 8, 1'b0, 0, 15, "R5 source 15");
    send(32'h1234_5678, 0, 8, 1'b0, 15, 2, "R5 destination 15");
    send(32'h1234_5678, 0, 8, 1'b0, 3, 13, "R5 source 13");
    send(32'h1234_5678, 4, 8, 1'b1, 14, 14, "R5 index 14 accepted");
    idle(3);
    for (int n = 0; n < 40; n++) begin
      int lsb, len;
      lsb = $urandom_range(0, 31);
      len = $urandom_range(1, 32 - lsb);
      send($urandom, lsb, len, 1'($urandom_range(0, 1)), $urandom_range(0, 12), $urandom_range(0, 12), "R1/R2 varied fields");
    end
    idle(3);
    send(32'hCAFE_0000, 16, 16, 1'b1, 0, 1, "R7 last before reset");
    idle(3);
    rst = 1'b1;
    lastGood = '0;
    idle(2);
    checkReset("R8 reset mid-run");
    rst = 1'b0;
    send(32'h1234_5678, 0, 0, 1'b0, 0, 1, "R6 reject after reset holds 0");
    idle(4);
    done = 1;
    if (sb.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R7: %0d outcomes missing, expected 0", sb.size());
    end
    finishRun();
  end
endmodule